// File: doc/BRIEF.md
# Accumulator-Style Integer Execution Unit

This block is the 64-bit combinational arithmetic and logic stage of a small accumulator-style core. The first source is always the destination register `ra`. The second operand is either a register value or an immediate that the decoder has already sign-extended. The caller picks which one to present. The unit returns a single 64-bit value, which the core writes back into `ra`.

One carry chain serves add, scaled add, subtract, reverse subtract and the four set-on-compare operations. A staged barrel shifter serves the two logical shifts and the arithmetic shift. Operand fetch, immediate decoding and condition flags are handled outside the block.

Top module: `alu_exec`

## Requirements
- R1: Operation code 0 (add) returns `ra_i + opb_i` modulo 2^64.
- R2: Operation code 1 (scaled add) returns `ra_i + 256 * opb_i` modulo 2^64.
- R3: Operation codes 2 (load immediate) and 3 (move) return `opb_i` unchanged.
- R4: Operation code 4 (subtract) returns `ra_i - opb_i`, and code 5 (reverse subtract) returns `opb_i - ra_i`, both modulo 2^64.
- R5: Operation codes 6, 7 and 8 return the bitwise AND, OR and XOR of `ra_i` and `opb_i`.
- R6: Operation code 9 returns 1 when `ra_i` is less than `opb_i` as signed two's-complement values, and code 10 returns 1 when it is greater. Otherwise both return 0. The result is zero-extended, so bits 63..1 are always 0.
- R7: Operation code 11 returns 1 when `ra_i` is less than `opb_i` as unsigned values, and code 12 returns 1 when it is greater. A sign-extended negative immediate counts as a large unsigned value. Bits 63..1 of the result are always 0.
- R8: Operation codes 13 (logical right), 14 (logical left) and 15 (arithmetic right) shift `ra_i` by `opb_i` mod 64 places. The arithmetic shift fills vacated bits with bit 63 of `ra_i`.
- R9: Bits 63..6 of `opb_i` have no effect on any shift. For example, an amount of 64 or 128 returns `ra_i` unchanged.
- R10: When `ra_i` equals `opb_i`, all four compare codes (9 to 12) return 0.
- R11: With `ra_i` and `opb_i` both zero, every operation code returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (0 to 15, see requirements) |
| ra_i | input | 64 | First source; the accumulator value |
| opb_i | input | 64 | Second operand: register value or sign-extended immediate |
| res_o | output | 64 | Result written back to the accumulator |

## Verification
In every cycle, the subtractor and the comparator draw on the same difference and carry out. A signed compare is therefore judged in exactly the cycles where a subtract of the same operands would overflow. The bench provokes this with operand pairs of opposite sign near both extremes, such as the most negative value against 1 and the most positive value against -1. It runs subtract, reverse subtract and all four compares on each pair in consecutive cycles, so a wrapped difference must never flip the compare outcome. Equal operands and unsigned pairs straddling bit 63 close off the remaining cases where the carry, sign and equality terms could disagree.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DATA_W = 64;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDS = 4'd1,
    OP_LDI  = 4'd2,
    OP_MOV  = 4'd3,
    OP_SUB  = 4'd4,
    OP_RSB  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_SLT  = 4'd9,
    OP_SGT  = 4'd10,
    OP_SLTU = 4'd11,
    OP_SGTU = 4'd12,
    OP_SRL  = 4'd13,
    OP_SLL  = 4'd14,
    OP_SRA  = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_sel_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 64
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  logic [W:0] full;

  always_comb full = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};

  assign sum_o   = full[W-1:0];
  assign carry_o = full[W];
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_sel_e   sel_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    unique case (sel_i)
      LG_AND:  y_o = a_i & b_i;
      LG_OR:   y_o = a_i | b_i;
      default: y_o = a_i ^ b_i;
    endcase
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W  = 64,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [SW-1:0] amt_i,
  input  logic          left_i,
  input  logic          arith_i,
  output logic [W-1:0]  data_o
);
  logic [W-1:0]      rev_in;
  logic [W-1:0]      rev_out;
  logic [SW:0][W-1:0] stg;
  logic              fill;

  // left shift is a right shift on the bit-reversed word
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i]  = data_i[W-1-i];
    assign rev_out[i] = stg[SW][W-1-i];
  end

  assign fill   = arith_i & ~left_i & data_i[W-1];
  assign stg[0] = left_i ? rev_in : data_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int S = 1 << k;
    assign stg[k+1] = amt_i[k] ? {{S{fill}}, stg[k][W-1:S]} : stg[k];
  end

  assign data_o = left_i ? rev_out : stg[SW];

  // R8
  always_comb begin
    if (!$isunknown({data_i, arith_i, left_i}) && arith_i && !left_i)
      sra_sign_chk: assert (data_o[W-1] == data_i[W-1]);
  end

  // R9
  always_comb begin
    if (!$isunknown({data_i, amt_i, left_i}) && amt_i == '0)
      zero_shift_chk: assert (data_o == data_i);
  end
endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    ra_i,
  input  logic [W-1:0]    opb_i,
  output logic [W-1:0]    res_o
);
  localparam int SW        = $clog2(W);
  localparam int SCALE_SH  = 8;

  alu_op_e    op;
  logic [W-1:0] add_x, add_y, sum;
  logic         add_cin, carry;
  logic         ovf, lt_s, lt_u, eq;
  logic [W-1:0] lg_y, sh_y;
  logic_sel_e   lg_sel;

  assign op = alu_op_e'(op_i);

  // operand steering for the single carry chain
  always_comb begin
    add_x   = ra_i;
    add_y   = ~opb_i;
    add_cin = 1'b1;
    unique case (op)
      OP_ADD:  begin add_y = opb_i;             add_cin = 1'b0; end
      OP_ADDS: begin add_y = opb_i << SCALE_SH; add_cin = 1'b0; end
      OP_RSB:  begin add_x = ~ra_i; add_y = opb_i; end
      default: ;
    endcase
  end

  alu_addsub #(.W(W)) u_addsub (
    .x_i    (add_x),
    .y_i    (add_y),
    .cin_i  (add_cin),
    .sum_o  (sum),
    .carry_o(carry)
  );

  // compare terms read off ra - b
  assign ovf  = (ra_i[W-1] ^ opb_i[W-1]) & (sum[W-1] ^ ra_i[W-1]);
  assign lt_s = sum[W-1] ^ ovf;
  assign lt_u = ~carry;
  assign eq   = (ra_i == opb_i);

  always_comb begin
    unique case (op)
      OP_OR:   lg_sel = LG_OR;
      OP_XOR:  lg_sel = LG_XOR;
      default: lg_sel = LG_AND;
    endcase
  end

  alu_logic #(.W(W)) u_logic (
    .a_i  (ra_i),
    .b_i  (opb_i),
    .sel_i(lg_sel),
    .y_o  (lg_y)
  );

  alu_shift #(.W(W), .SW(SW)) u_shift (
    .data_i (ra_i),
    .amt_i  (opb_i[SW-1:0]),
    .left_i (op == OP_SLL),
    .arith_i(op == OP_SRA),
    .data_o (sh_y)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADDS, OP_SUB, OP_RSB: res_o = sum;
      OP_LDI, OP_MOV:                  res_o = opb_i;
      OP_AND, OP_OR, OP_XOR:           res_o = lg_y;
      OP_SLT:  res_o = {{(W-1){1'b0}}, lt_s};
      OP_SGT:  res_o = {{(W-1){1'b0}}, ~lt_s & ~eq};
      OP_SLTU: res_o = {{(W-1){1'b0}}, lt_u};
      OP_SGTU: res_o = {{(W-1){1'b0}}, ~lt_u & ~eq};
      default: res_o = sh_y;
    endcase
  end

  // R1
  always_comb begin
    if (!$isunknown({op_i, ra_i, opb_i}) && op == OP_ADD)
      add_sum_chk: assert (res_o - opb_i == ra_i);
  end

  // R4
  always_comb begin
    if (!$isunknown({op_i, ra_i, opb_i}) && op == OP_RSB)
      rsb_sum_chk: assert (res_o + ra_i == opb_i);
  end

  // R6
  always_comb begin
    if (!$isunknown({op_i, ra_i, opb_i}) && (op == OP_SLT || op == OP_SGT || op == OP_SLTU || op == OP_SGTU))
      cmp_width_chk: assert (res_o[W-1:1] == '0);
  end

  // R10
  always_comb begin
    if (!$isunknown({op_i, ra_i, opb_i}) && eq && (op == OP_SLT || op == OP_SGT || op == OP_SLTU || op == OP_SGTU))
      cmp_equal_chk: assert (res_o == '0);
  end

  // R3
  always_comb begin
    if (!$isunknown({op_i, ra_i, opb_i}) && (op == OP_LDI || op == OP_MOV))
      pass_b_chk: assert (res_o == opb_i);
  end
endmodule

// File: tb/alu_exec_tb_top.sv
module alu_exec_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op;
  logic [63:0] ra, opb;
  logic [63:0] res;

  int checks = 0;
  int fails  = 0;
  bit drv_done = 1'b0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  alu_exec dut_i (
    .op_i (op),
    .ra_i (ra),
    .opb_i(opb),
    .res_o(res)
  );

  function automatic logic [63:0] model(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b);
    case (o)
      4'd0:  return a + b;
      4'd1:  return a + b * 64'd256;
      4'd2, 4'd3: return b;
      4'd4:  return a - b;
      4'd5:  return b - a;
      4'd6:  return a & b;
      4'd7:  return a | b;
      4'd8:  return a ^ b;
      4'd9:  return {63'd0, $signed(a) < $signed(b)};
      4'd10: return {63'd0, $signed(a) > $signed(b)};
      4'd11: return {63'd0, a < b};
      4'd12: return {63'd0, a > b};
      4'd13: return a >> b[5:0];
      4'd14: return a << b[5:0];
      default: return 64'($signed(a) >>> b[5:0]);
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4, 4'd5: return "R4";
      4'd6, 4'd7, 4'd8: return "R5";
      4'd9, 4'd10: return "R6";
      4'd11, 4'd12: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic drive(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b, input string t);
    @(posedge clk);
    op  <= o;
    ra  <= a;
    opb <= b;
    exp_q.push_back(model(o, a, b));
    tag_q.push_back(t);
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [63:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (res !== e) begin
        fails++;
        $display("FAIL %s op=%0d ra=%h b=%h actual=%h expected=%h", t, op, ra, opb, res, e);
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    logic [63:0] pa[6];
    logic [63:0] pb[6];
    op = '0; ra = '0; opb = '0;
    repeat (3) @(posedge clk);
    rst_ni <= 1'b1;

    // R11: zero inputs across every code
    for (int o = 0; o < 16; o++) drive(4'(o), 64'd0, 64'd0, "R11");

    drive(4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R1");
    drive(4'd0, 64'd100, 64'hFFFF_FFFF_FFFF_FF80, "R1");
    drive(4'd1, 64'd5, 64'hFFFF_FFFF_FFFF_FFFF, "R2");
    drive(4'd1, 64'h1234, 64'd127, "R2");
    drive(4'd2, 64'hDEAD_BEEF, 64'hFFFF_FFFF_FFFF_FF80, "R3");
    drive(4'd3, 64'hDEAD_BEEF, 64'h0123_4567_89AB_CDEF, "R3");
    drive(4'd4, 64'd3, 64'd10, "R4");
    drive(4'd5, 64'd3, 64'd10, "R4");
    drive(4'd5, 64'd7, 64'hFFFF_FFFF_FFFF_FFE0, "R4");
    drive(4'd6, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_00FF_FF00, "R5");
    drive(4'd7, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_00FF_FF00, "R5");
    drive(4'd8, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_00FF_FF00, "R5");

    // compare and subtract on overflowing operand pairs: R6 R7
    pa = '{64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
           64'd1, 64'h8000_0000_0000_0000, 64'd5};
    pb = '{64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1,
           64'hFFFF_FFFF_FFFF_FFE0, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFB};
    for (int i = 0; i < 6; i++) begin
      drive(4'd4, pa[i], pb[i], "R4");
      drive(4'd5, pa[i], pb[i], "R4");
      drive(4'd9, pa[i], pb[i], "R6");
      drive(4'd10, pa[i], pb[i], "R6");
      drive(4'd11, pa[i], pb[i], "R7");
      drive(4'd12, pa[i], pb[i], "R7");
    end

    // R10: equal operands
    for (int o = 9; o <= 12; o++) begin
      drive(4'(o), 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R10");
      drive(4'(o), 64'd42, 64'd42, "R10");
    end

    // R8 shifts
    for (int s = 0; s < 64; s += 9) begin
      drive(4'd13, 64'h8123_4567_89AB_CDEF, 64'(s), "R8");
      drive(4'd14, 64'h8123_4567_89AB_CDEF, 64'(s), "R8");
      drive(4'd15, 64'h8123_4567_89AB_CDEF, 64'(s), "R8");
    end
    drive(4'd15, 64'h8000_0000_0000_0000, 64'd63, "R8");
    drive(4'd13, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R8");

    // R9: high amount bits ignored
    drive(4'd13, 64'hCAFE_0000_0000_BEEF, 64'd64, "R9");
    drive(4'd14, 64'hCAFE_0000_0000_BEEF, 64'd128, "R9");
    drive(4'd15, 64'hCAFE_0000_0000_BEEF, 64'hFFFF_FFFF_FFFF_FFC4, "R9");

    // mixed patterns
    for (int i = 0; i < 200; i++) begin
      logic [3:0]  o;
      logic [63:0] a, b;
      o = 4'($urandom_range(0, 15));
      a = {$urandom(), $urandom()};
      b = (i % 2 == 0) ? {$urandom(), $urandom()} : 64'($signed(8'($urandom())));
      drive(o, a, b, tag_of(o));
    end

    repeat (3) @(posedge clk);
    drv_done = 1'b1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!drv_done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      summary();
    end
  end
endmodule